// File: doc/BRIEF.md
# Echo Canceller Group Router

This block steers PCM samples for a pair of echo-canceller channels, called A and B, that share a time-division PCM interface. Software writes a small control word for each channel and a PCM format code. The block decodes those words into one of three group topologies. In Normal, the two channels run side by side on separate timeslots. In Back-to-Back, two cancellers face opposite directions of a single channel. In Extended Delay, the two cancellers are chained into one canceller with a doubled tail.

For each timeslot strobe, the block presents a reference sample and a send sample to each canceller core that takes part. The cores sit outside this block and return their error samples in the same cycle. The block then registers the receive and send outputs for that timeslot. Where mute is requested, it substitutes the silence code of the selected PCM encoding. Configuration changes wait for the frame boundary strobe, so no frame is split across two topologies.

Top module: `egr_group`

## Requirements
- R1: After reset the group is in Normal mode (mode code 0), `conflict`, `cfg_err` and `out_vld` are 0, and `rout`/`sout` are zero.
- R2: Register writes go to pending storage. The active configuration, `mode`, `conflict` and `cfg_err` change only on the clock edge where `frame_stb` is 1. On any other edge `mode` keeps its value.
- R3: Register addresses are 0 for channel A control, 1 for channel B control and 2 for format (bits 1:0). Control bits are bit0 chain, bit1 face-to-face, bit2 receive mute and bit3 send mute. Mode codes are 0 Normal, 1 Back-to-Back and 2 Extended Delay. Extended Delay is selected by bit0 of A. Back-to-Back is selected only when bit1 is set in both A and B. Every other case gives Normal.
- R4: When bit0 of A is set and bit1 is set in both A and B, Extended Delay wins and `conflict` is 1.
- R5: `cfg_err` is 1 whenever the active B control word has bit0 set.
- R6: In Normal mode, a slot A strobe feeds core A with ref = receive sample and snd = send sample. `rout` = ref and `sout` = core A error. A slot B strobe does the same with core B and B's control bits.
- R7: In Back-to-Back mode, a slot A strobe drives core A with (ref = rin, snd = sin) and core B with (ref = sin, snd = rin). Then `sout` = core A error and `rout` = core B error. Receive mute has no effect. B's send-mute bit quiets `rout`.
- R8: In Extended Delay mode, a slot A strobe drives core A with (ref = muted rin, snd = sin) and core B with (ref = muted rin, snd = core A error). Then `sout` = core B error and `rout` = muted rin.
- R9: In Back-to-Back or Extended Delay, a slot B strobe asserts no core valid, and `rout` and `sout` both take the fill value 16'h7FFF.
- R10: In Normal and Extended Delay, the owning channel's receive-mute bit replaces rin with the quiet code on both the core reference and `rout`.
- R11: The owning channel's send-mute bit replaces `sout` with the quiet code.
- R12: The quiet code depends on the format. Format 0 (linear) gives 16'h0000, 1 (sign-magnitude) gives 16'h0080, 2 (mu-law) gives 16'h00FF and 3 (A-law) gives 16'h00D5.
- R13: Core ports respond in the strobe cycle. `rout`, `sout` and `out_vld` are registered and appear on the edge that ends the strobe cycle, with `out_slot` = 1 for slot B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register address |
| wr_data | input | 4 | Register write data |
| frame_stb | input | 1 | Frame boundary; loads pending configuration |
| slot_a_stb | input | 1 | Timeslot A sample strobe |
| slot_b_stb | input | 1 | Timeslot B sample strobe |
| rin | input | SAMPLE_W | Receive-side input sample |
| sin | input | SAMPLE_W | Send-side input sample |
| core_a_ref | output | SAMPLE_W | Core A reference sample |
| core_a_snd | output | SAMPLE_W | Core A send sample |
| core_a_vld | output | 1 | Core A sample valid |
| core_a_err | input | SAMPLE_W | Core A error sample |
| core_b_ref | output | SAMPLE_W | Core B reference sample |
| core_b_snd | output | SAMPLE_W | Core B send sample |
| core_b_vld | output | 1 | Core B sample valid |
| core_b_err | input | SAMPLE_W | Core B error sample |
| rout | output | SAMPLE_W | Registered receive-side output |
| sout | output | SAMPLE_W | Registered send-side output |
| out_vld | output | 1 | Output sample valid |
| out_slot | output | 1 | Timeslot of the output sample (0 A, 1 B) |
| mode | output | 2 | Active topology code |
| conflict | output | 1 | Both chain and face-to-face were requested |
| cfg_err | output | 1 | B control bit0 is set |

## Verification
The assertions assume that the two timeslot strobes never fire in the same cycle, and that the core error inputs are a same-cycle function of the core ports. The bench drives one strobe at a time and models each core as send minus reference, with no state. Frame strobes are issued only in cycles without register writes or sample strobes. The sweep covers every pair of control words under every format, so each topology, each mute combination and the conflict and error flags are all reached.

// File: rtl/egr_pkg.sv
package egr_pkg;
  localparam int CTL_W = 4;
  localparam int FMT_W = 2;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_B2B    = 2'd1,
    MODE_EXT    = 2'd2
  } grp_mode_e;

  typedef enum logic [FMT_W-1:0] {
    FMT_LIN  = 2'd0,
    FMT_SMAG = 2'd1,
    FMT_ULAW = 2'd2,
    FMT_ALAW = 2'd3
  } pcm_fmt_e;

  // bit3 send mute, bit2 receive mute, bit1 face-to-face, bit0 chain
  typedef struct packed {
    logic mute_s;
    logic mute_r;
    logic b2b;
    logic ext;
  } ch_ctl_t;

  localparam logic [1:0] ADDR_CTL_A = 2'd0;
  localparam logic [1:0] ADDR_CTL_B = 2'd1;
  localparam logic [1:0] ADDR_FMT   = 2'd2;
endpackage

// File: rtl/egr_quiet.sv
module egr_quiet import egr_pkg::*; #(
  parameter int SAMPLE_W = 16
) (
  input  pcm_fmt_e              fmt,
  output logic [SAMPLE_W-1:0]   code
);
  localparam int CW = 8;

  logic [CW-1:0] code8;

  always_comb begin
    case (fmt)
      FMT_LIN:  code8 = 8'h00;
      FMT_SMAG: code8 = 8'h80;
      FMT_ULAW: code8 = 8'hFF;
      default:  code8 = 8'hD5;
    endcase
  end

  generate
    if (SAMPLE_W > CW) begin : g_wide
      assign code = {{(SAMPLE_W-CW){1'b0}}, code8};
    end else begin : g_narrow
      assign code = code8[SAMPLE_W-1:0];
    end
  endgenerate

  // R12: linear format always yields all-zero silence
  always_comb begin
    if (fmt == FMT_LIN) assert_lin_zero_R12: assert (code == '0);
  end
endmodule

// File: rtl/egr_cfg.sv
module egr_cfg import egr_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             frame_stb,
  output ch_ctl_t          act_a,
  output ch_ctl_t          act_b,
  output pcm_fmt_e         act_fmt,
  output grp_mode_e        mode,
  output logic             conflict,
  output logic             cfg_err
);
  ch_ctl_t   pend_a, pend_b;
  pcm_fmt_e  pend_fmt;
  grp_mode_e nxt_mode;
  logic      nxt_b2b_req;

  always_comb begin
    nxt_b2b_req = pend_a.b2b & pend_b.b2b;
    if (pend_a.ext)       nxt_mode = MODE_EXT;
    else if (nxt_b2b_req) nxt_mode = MODE_B2B;
    else                  nxt_mode = MODE_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_a   <= '0;
      pend_b   <= '0;
      pend_fmt <= FMT_LIN;
      act_a    <= '0;
      act_b    <= '0;
      act_fmt  <= FMT_LIN;
      mode     <= MODE_NORMAL;
      conflict <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          ADDR_CTL_A: pend_a   <= ch_ctl_t'(wr_data);
          ADDR_CTL_B: pend_b   <= ch_ctl_t'(wr_data);
          ADDR_FMT:   pend_fmt <= pcm_fmt_e'(wr_data[FMT_W-1:0]);
          default: ;
        endcase
      end
      if (frame_stb) begin
        act_a    <= pend_a;
        act_b    <= pend_b;
        act_fmt  <= pend_fmt;
        mode     <= nxt_mode;
        conflict <= pend_a.ext & nxt_b2b_req;
        cfg_err  <= pend_b.ext;
      end
    end
  end

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(mode));
  assert_mode_legal_R3: assert property (@(posedge clk) disable iff (rst)
    mode != 2'd3);
  assert_conflict_ext_R4: assert property (@(posedge clk) disable iff (rst)
    conflict |-> mode == MODE_EXT);
  assert_err_tracks_b_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_err == act_b.ext);
endmodule

// File: rtl/egr_router.sv
module egr_router import egr_pkg::*; #(
  parameter int                 SAMPLE_W = 16,
  parameter logic [SAMPLE_W-1:0] FILL    = 16'h7FFF
) (
  input  logic                clk,
  input  logic                rst,
  input  grp_mode_e           mode,
  input  ch_ctl_t             act_a,
  input  ch_ctl_t             act_b,
  input  logic [SAMPLE_W-1:0] quiet,
  input  logic                slot_a_stb,
  input  logic                slot_b_stb,
  input  logic [SAMPLE_W-1:0] rin,
  input  logic [SAMPLE_W-1:0] sin,
  output logic [SAMPLE_W-1:0] core_a_ref,
  output logic [SAMPLE_W-1:0] core_a_snd,
  output logic                core_a_vld,
  input  logic [SAMPLE_W-1:0] core_a_err,
  output logic [SAMPLE_W-1:0] core_b_ref,
  output logic [SAMPLE_W-1:0] core_b_snd,
  output logic                core_b_vld,
  input  logic [SAMPLE_W-1:0] core_b_err,
  output logic [SAMPLE_W-1:0] rout,
  output logic [SAMPLE_W-1:0] sout,
  output logic                out_vld,
  output logic                out_slot
);
  logic [SAMPLE_W-1:0] rin_qa, rin_qb, rout_n, sout_n;

  assign rin_qa = act_a.mute_r ? quiet : rin;
  assign rin_qb = act_b.mute_r ? quiet : rin;

  always_comb begin
    core_a_ref = '0; core_a_snd = '0; core_a_vld = 1'b0;
    core_b_ref = '0; core_b_snd = '0; core_b_vld = 1'b0;
    rout_n = FILL;   sout_n = FILL;
    if (slot_a_stb) begin
      case (mode)
        MODE_B2B: begin
          core_a_ref = rin;  core_a_snd = sin;  core_a_vld = 1'b1;
          core_b_ref = sin;  core_b_snd = rin;  core_b_vld = 1'b1;
          sout_n = act_a.mute_s ? quiet : core_a_err;
          rout_n = act_b.mute_s ? quiet : core_b_err;
        end
        MODE_EXT: begin
          core_a_ref = rin_qa; core_a_snd = sin;        core_a_vld = 1'b1;
          core_b_ref = rin_qa; core_b_snd = core_a_err; core_b_vld = 1'b1;
          rout_n = rin_qa;
          sout_n = act_a.mute_s ? quiet : core_b_err;
        end
        default: begin
          core_a_ref = rin_qa; core_a_snd = sin; core_a_vld = 1'b1;
          rout_n = rin_qa;
          sout_n = act_a.mute_s ? quiet : core_a_err;
        end
      endcase
    end else if (slot_b_stb && mode == MODE_NORMAL) begin
      core_b_ref = rin_qb; core_b_snd = sin; core_b_vld = 1'b1;
      rout_n = rin_qb;
      sout_n = act_b.mute_s ? quiet : core_b_err;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rout     <= '0;
      sout     <= '0;
      out_vld  <= 1'b0;
      out_slot <= 1'b0;
    end else begin
      out_vld <= slot_a_stb | slot_b_stb;
      if (slot_a_stb | slot_b_stb) begin
        rout     <= rout_n;
        sout     <= sout_n;
        out_slot <= slot_b_stb & ~slot_a_stb;
      end
    end
  end

  assert_one_slot_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({slot_a_stb, slot_b_stb}));
  assert_out_follows_R13: assert property (@(posedge clk) disable iff (rst)
    (slot_a_stb | slot_b_stb) |=> out_vld);
  assert_fill_slot_b_R9: assert property (@(posedge clk) disable iff (rst)
    (slot_b_stb && mode != MODE_NORMAL) |=> (rout == FILL && sout == FILL));
  assert_no_core_b_slot_R9: assert property (@(posedge clk) disable iff (rst)
    (slot_b_stb && mode != MODE_NORMAL) |-> !(core_a_vld || core_b_vld));
  assert_b2b_cross_R7: assert property (@(posedge clk) disable iff (rst)
    (slot_a_stb && mode == MODE_B2B) |-> (core_b_ref == sin && core_b_snd == rin));
  assert_ext_chain_R8: assert property (@(posedge clk) disable iff (rst)
    (slot_a_stb && mode == MODE_EXT) |-> (core_b_snd == core_a_err && core_b_ref == core_a_ref));
endmodule

// File: rtl/egr_group.sv
module egr_group import egr_pkg::*; #(
  parameter int                  SAMPLE_W = 16,
  parameter logic [SAMPLE_W-1:0] FILL     = 16'h7FFF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [CTL_W-1:0]    wr_data,
  input  logic                frame_stb,
  input  logic                slot_a_stb,
  input  logic                slot_b_stb,
  input  logic [SAMPLE_W-1:0] rin,
  input  logic [SAMPLE_W-1:0] sin,
  output logic [SAMPLE_W-1:0] core_a_ref,
  output logic [SAMPLE_W-1:0] core_a_snd,
  output logic                core_a_vld,
  input  logic [SAMPLE_W-1:0] core_a_err,
  output logic [SAMPLE_W-1:0] core_b_ref,
  output logic [SAMPLE_W-1:0] core_b_snd,
  output logic                core_b_vld,
  input  logic [SAMPLE_W-1:0] core_b_err,
  output logic [SAMPLE_W-1:0] rout,
  output logic [SAMPLE_W-1:0] sout,
  output logic                out_vld,
  output logic                out_slot,
  output logic [1:0]          mode,
  output logic                conflict,
  output logic                cfg_err
);
  ch_ctl_t             act_a, act_b;
  pcm_fmt_e            act_fmt;
  grp_mode_e           mode_q;
  logic [SAMPLE_W-1:0] quiet;

  egr_cfg i_cfg (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .frame_stb,
    .act_a, .act_b, .act_fmt, .mode(mode_q), .conflict, .cfg_err
  );

  egr_quiet #(.SAMPLE_W(SAMPLE_W)) i_quiet (.fmt(act_fmt), .code(quiet));

  egr_router #(.SAMPLE_W(SAMPLE_W), .FILL(FILL)) i_router (
    .clk, .rst, .mode(mode_q), .act_a, .act_b, .quiet,
    .slot_a_stb, .slot_b_stb, .rin, .sin,
    .core_a_ref, .core_a_snd, .core_a_vld, .core_a_err,
    .core_b_ref, .core_b_snd, .core_b_vld, .core_b_err,
    .rout, .sout, .out_vld, .out_slot
  );

  assign mode = mode_q;
endmodule

// File: tb/test_egr_group.sv
`timescale 1ns/1ps
module test_egr_group;
  localparam int W = 16;
  localparam logic [W-1:0] FILL = 16'h7FFF;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0; logic [1:0] wr_addr = 0; logic [3:0] wr_data = 0;
  logic frame_stb = 0, slot_a_stb = 0, slot_b_stb = 0;
  logic [W-1:0] rin = 0, sin = 0;
  logic [W-1:0] core_a_ref, core_a_snd, core_a_err, core_b_ref, core_b_snd, core_b_err;
  logic core_a_vld, core_b_vld;
  logic [W-1:0] rout, sout;
  logic out_vld, out_slot, conflict, cfg_err;
  logic [1:0] mode;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // Stateless core model: error = send - reference
  assign core_a_err = core_a_snd - core_a_ref;
  assign core_b_err = core_b_snd - core_b_ref;

  egr_group i_egr_group (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .frame_stb, .slot_a_stb, .slot_b_stb,
    .rin, .sin, .core_a_ref, .core_a_snd, .core_a_vld, .core_a_err,
    .core_b_ref, .core_b_snd, .core_b_vld, .core_b_err,
    .rout, .sout, .out_vld, .out_slot, .mode, .conflict, .cfg_err
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] qcode(input int f);
    case (f)
      0: return 16'h0000;
      1: return 16'h0080;
      2: return 16'h00FF;
      default: return 16'h00D5;
    endcase
  endfunction

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int prev_mode;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 mode", mode, 0);
    chk("R1 conflict", conflict, 0);
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 out_vld", out_vld, 0);
    chk("R1 rout", rout, 0);
    chk("R1 sout", sout, 0);
    prev_mode = 0;

    for (int f = 0; f < 4; f++) begin
      for (int ca = 0; ca < 16; ca++) begin
        for (int cb = 0; cb < 16; cb++) begin
          int em;
          logic [W-1:0] q, ra, rq, ea, eb;
          logic [W-1:0] exp_r, exp_s;
          logic mra, msa, mrb, msb;
          wr(2'd2, 4'(f));
          wr(2'd0, 4'(ca));
          wr(2'd1, 4'(cb));
          chk("R2 mode held before frame", mode, prev_mode);
          @(negedge clk); frame_stb = 1;
          @(negedge clk); frame_stb = 0;
          em = (ca & 1) ? 2 : (((ca >> 1) & 1) && ((cb >> 1) & 1)) ? 1 : 0;
          chk("R3 mode decode", mode, em);
          chk("R4 conflict", conflict, ((ca & 1) && ((ca >> 1) & 1) && ((cb >> 1) & 1)) ? 1 : 0);
          chk("R5 cfg_err", cfg_err, cb & 1);
          prev_mode = em;
          q = qcode(f);
          mra = ca[2]; msa = ca[3]; mrb = cb[2]; msb = cb[3];

          // slot A
          ra = W'((ca * 16 + cb) * 977 + f * 131 + 17);
          @(negedge clk);
          rin = ra; sin = W'(ra * 7 + 12345); slot_a_stb = 1;
          #1;
          chk("R13 core_a_vld slot A", core_a_vld, 1);
          chk("R13 core_b_vld slot A", core_b_vld, em != 0);
          if (em == 1) begin
            exp_s = msa ? q : W'(sin - rin);
            exp_r = msb ? q : W'(rin - sin);
          end else if (em == 2) begin
            rq = mra ? q : rin;
            ea = W'(sin - rq);
            eb = W'(ea - rq);
            exp_r = rq;
            exp_s = msa ? q : eb;
          end else begin
            rq = mra ? q : rin;
            exp_r = rq;
            exp_s = msa ? q : W'(sin - rq);
          end
          @(negedge clk); slot_a_stb = 0;
          chk("R13 out_vld after slot A", out_vld, 1);
          chk("R13 out_slot A", out_slot, 0);
          chk(em == 1 ? "R7 rout" : em == 2 ? "R8 R10 rout" : "R6 R10 rout", rout, exp_r);
          chk(em == 1 ? "R7 R11 sout" : em == 2 ? "R8 R11 R12 sout" : "R6 R11 R12 sout", sout, exp_s);

          // slot B
          @(negedge clk);
          rin = W'(ra ^ 16'h5A3C); sin = W'(ra + 16'h0F0F); slot_b_stb = 1;
          #1;
          chk("R9 core_a_vld slot B", core_a_vld, 0);
          chk("R9 core_b_vld slot B", core_b_vld, em == 0);
          if (em == 0) begin
            rq = mrb ? q : rin;
            exp_r = rq;
            exp_s = msb ? q : W'(sin - rq);
          end else begin
            exp_r = FILL; exp_s = FILL;
          end
          @(negedge clk); slot_b_stb = 0;
          chk("R13 out_slot B", out_slot, 1);
          chk(em == 0 ? "R6 R10 rout slot B" : "R9 rout fill", rout, exp_r);
          chk(em == 0 ? "R6 R11 sout slot B" : "R9 sout fill", sout, exp_s);
          chk("R13 out_vld drops", (em >= 0) ? 32'(out_vld) : 32'(out_vld), 1);
          @(negedge clk);
          chk("R13 out_vld idle", out_vld, 0);
        end
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule